// File: doc/BRIEF.md
# Configuration Sequencer with Error Recovery

This block is the control state machine that runs one configuration cycle of a target programmable device. Coming out of reset, it captures a three-bit page selection and then fetches a fixed block of 32 sixteen-bit option words from a synchronous flash read port. The fetch starts at word address 0x8000. Once the options are loaded, it waits for the target to signal readiness. It then starts the external data shifter and keeps it running until the shifter reports that the last bit has gone out. After that it watches the target's done line.

Two failures are handled:

- **Done timeout.** The done line may fail to rise within a window counted in configuration clock ticks. The sequencer then drives the target's output-enable line low for a fixed number of system clocks. This forces the target back into a fresh cycle.
- **Corruption abort.** The target may pull its status line low during the transfer. The sequencer then halts the shifter at once and waits until the line is released.

After a successful cycle, the sequencer parks the shifter and stops driving the flash port. It stays there until the next reset.

The target status and done inputs pass through two-flop synchronisers before any decision uses them. Two saturating counters record how many times each kind of failure has occurred. The state is brought out on a port.

Top module: `cfg_seq`

## Requirements
- R1: In the first clock after reset is released, the state is SAMPLE (state code 0) and `page_sel_i` is captured into `cfg_page_o`. Later changes of `page_sel_i` have no effect on `cfg_page_o`, including across restarts, until the next reset.
- R2: In LOAD (code 1), `flash_rd_o` is high and `flash_addr_o` equals 0x8000 plus the number of words accepted so far. A word is accepted on each clock with `flash_valid_i` high. The word returned for address 0x8000 is held on `opt_cfg_o`. After the 32nd accepted word the state becomes WAIT_RDY (code 2). `xfer_run_o` stays low during the load.
- R3: The state leaves WAIT_RDY for XFER (code 3) only when the synchronised status is high and the synchronised done is low. `xfer_start_o` is high for exactly the first XFER cycle. `xfer_run_o` is high in XFER and WAIT_DONE (code 4).
- R4: `xfer_last_i` sampled high in XFER moves the state to WAIT_DONE on that edge. A synchronised done high in WAIT_DONE moves the state to PARK (code 7).
- R5: The 64th `dclk_tick_i` pulse counted in WAIT_DONE without done moves the state to OE_PULSE (code 5) and increments `done_err_cnt_o`. Fewer ticks cause no error.
- R6: `tgt_oe_o` is high except in OE_PULSE, where it is low for exactly 16 clocks. The state then returns to WAIT_RDY, and a new transfer starts once the target is ready.
- R7: Status low in XFER or WAIT_DONE moves the state to CRC_HALT (code 6) on the third clock edge after the pin falls, because of the two synchroniser stages. In CRC_HALT `xfer_run_o` is low and `crc_err_cnt_o` has been incremented once. The state stays there until status is high again, then returns to WAIT_RDY.
- R8: In PARK the outputs are as follows, and the state holds regardless of the target pins until reset:
  - `park_o` is high.
  - `xfer_run_o`, `flash_rd_o` and `flash_bus_en_o` are low.
  - `flash_addr_o` is 0.
- R9: Both error counters are 0 after reset and saturate at 2^CNT_W-1, which is 15 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| page_sel_i | input | 3 | Configuration page select, captured once after reset |
| flash_addr_o | output | 16 | Flash word address, 0 when idle |
| flash_rd_o | output | 1 | Flash read request |
| flash_data_i | input | 16 | Flash read data |
| flash_valid_i | input | 1 | Flash read data valid |
| flash_bus_en_o | output | 1 | Flash address/control drive enable, low once released |
| tgt_status_i | input | 1 | Target status line, high when ready, low on error |
| tgt_done_i | input | 1 | Target configuration done line |
| tgt_oe_o | output | 1 | Output-enable to target, pulsed low to force restart |
| xfer_start_o | output | 1 | One-cycle start pulse to the data shifter |
| xfer_run_o | output | 1 | Shifter clock enable, low pauses/halts the transfer |
| xfer_last_i | input | 1 | Shifter reports the last data bit was sent |
| dclk_tick_i | input | 1 | One pulse per configuration clock cycle |
| park_o | output | 1 | Shifter holds clock low and data high |
| cfg_page_o | output | 3 | Captured page select |
| opt_cfg_o | output | 16 | First option word |
| done_err_cnt_o | output | 4 | Saturating count of done timeouts |
| crc_err_cnt_o | output | 4 | Saturating count of corruption aborts |
| state_o | output | 3 | Current state code |

## Verification
The bench strikes the timeout window with an irregular tick stream and expects the error on exactly the 64th tick. A counter that counts system clocks, or that is off by one, would restart early or late. A successful run with done raised after 40 ticks must leave the done-error count unchanged. It checks that a status drop halts the transfer on exactly the third edge, both in XFER and in WAIT_DONE. It also checks that the state holds in CRC_HALT while status stays low; a design that rearmed early or skipped the synchroniser would show up there. It also checks that the output-enable pulse spans exactly 16 clocks, and that the page select changed after the first clock is ignored. Finally, 18 aborts in a row must leave the corruption counter at 15 rather than wrapping.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_SAMPLE    = 3'd0,
    ST_LOAD      = 3'd1,
    ST_WAIT_RDY  = 3'd2,
    ST_XFER      = 3'd3,
    ST_WAIT_DONE = 3'd4,
    ST_OE_PULSE  = 3'd5,
    ST_CRC_HALT  = 3'd6,
    ST_PARK      = 3'd7
  } seq_state_e;
endpackage

// File: rtl/cfg_seq_sync.sv
module cfg_seq_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/cfg_seq_opt_loader.sv
module cfg_seq_opt_loader #(
  parameter int                ADDR_W = 16,
  parameter int                DATA_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 16'h8000,
  parameter int                WORDS  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              done_o,
  output logic [DATA_W-1:0] word0_o
);
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] w0_q;
  logic              take;

  assign take    = en_i && valid_i;
  assign rd_o    = en_i;
  assign addr_o  = en_i ? (BASE + ADDR_W'(idx_q)) : '0;
  assign done_o  = take && (idx_q == IDX_W'(WORDS - 1));
  assign word0_o = w0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      w0_q  <= '0;
    end else if (take) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == '0) w0_q <= data_i;
    end
  end
endmodule

// File: rtl/cfg_seq_cnt.sv
// Window counter: last_o flags the increment that completes LIMIT counts.
module cfg_seq_cnt #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign last_o = inc_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_seq_satcnt.sv
module cfg_seq_satcnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (inc_i && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end
  assign cnt_o = cnt_q;
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_seq_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] OPT_BASE  = 16'h8000,
  parameter int                OPT_WORDS = 32,
  parameter int                PAGE_W    = 3,
  parameter int                DONE_TMO  = 64,
  parameter int                OE_PULSE  = 16,
  parameter int                CNT_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAGE_W-1:0] page_sel_i,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic              flash_rd_o,
  input  logic [DATA_W-1:0] flash_data_i,
  input  logic              flash_valid_i,
  output logic              flash_bus_en_o,
  input  logic              tgt_status_i,
  input  logic              tgt_done_i,
  output logic              tgt_oe_o,
  output logic              xfer_start_o,
  output logic              xfer_run_o,
  input  logic              xfer_last_i,
  input  logic              dclk_tick_i,
  output logic              park_o,
  output logic [PAGE_W-1:0] cfg_page_o,
  output logic [DATA_W-1:0] opt_cfg_o,
  output logic [CNT_W-1:0]  done_err_cnt_o,
  output logic [CNT_W-1:0]  crc_err_cnt_o,
  output logic [2:0]        state_o
);
  localparam int N_ERR = 2;

  seq_state_e        state_q, state_d;
  logic              status_s, done_s;
  logic              load_done, tmo_last, oe_last;
  logic              start_q;
  logic [PAGE_W-1:0] page_q;
  logic [N_ERR-1:0]  err_inc;
  logic [CNT_W-1:0]  err_cnt [N_ERR];

  cfg_seq_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({tgt_status_i, tgt_done_i}),
    .q_o   ({status_s, done_s})
  );

  cfg_seq_opt_loader #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(OPT_BASE), .WORDS(OPT_WORDS)
  ) u_load (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_LOAD),
    .data_i (flash_data_i),
    .valid_i(flash_valid_i),
    .addr_o (flash_addr_o),
    .rd_o   (flash_rd_o),
    .done_o (load_done),
    .word0_o(opt_cfg_o)
  );

  // done window counts configuration clock ticks, not system clocks
  cfg_seq_cnt #(.LIMIT(DONE_TMO)) u_tmo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q != ST_WAIT_DONE),
    .inc_i ((state_q == ST_WAIT_DONE) && dclk_tick_i),
    .last_o(tmo_last)
  );

  cfg_seq_cnt #(.LIMIT(OE_PULSE)) u_oep (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q != ST_OE_PULSE),
    .inc_i (state_q == ST_OE_PULSE),
    .last_o(oe_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SAMPLE:    state_d = ST_LOAD;
      ST_LOAD:      if (load_done) state_d = ST_WAIT_RDY;
      ST_WAIT_RDY:  if (status_s && !done_s) state_d = ST_XFER;
      ST_XFER: begin
        if (!status_s)        state_d = ST_CRC_HALT;
        else if (xfer_last_i) state_d = ST_WAIT_DONE;
      end
      ST_WAIT_DONE: begin
        if (done_s)           state_d = ST_PARK;
        else if (!status_s)   state_d = ST_CRC_HALT;
        else if (tmo_last)    state_d = ST_OE_PULSE;
      end
      ST_OE_PULSE:  if (oe_last) state_d = ST_WAIT_RDY;
      ST_CRC_HALT:  if (status_s) state_d = ST_WAIT_RDY;
      ST_PARK:      state_d = ST_PARK;
      default:      state_d = ST_SAMPLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SAMPLE;
      start_q <= 1'b0;
      page_q  <= '0;
    end else begin
      state_q <= state_d;
      start_q <= (state_q == ST_WAIT_RDY) && (state_d == ST_XFER);
      if (state_q == ST_SAMPLE) page_q <= page_sel_i;
    end
  end

  assign err_inc[0] = (state_q == ST_WAIT_DONE) && (state_d == ST_OE_PULSE);
  assign err_inc[1] = (state_q != ST_CRC_HALT) && (state_d == ST_CRC_HALT);

  for (genvar g = 0; g < N_ERR; g++) begin : g_err
    cfg_seq_satcnt #(.W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (err_inc[g]),
      .cnt_o (err_cnt[g])
    );
  end

  assign done_err_cnt_o = err_cnt[0];
  assign crc_err_cnt_o  = err_cnt[1];
  assign flash_bus_en_o = (state_q != ST_PARK);
  assign tgt_oe_o       = (state_q != ST_OE_PULSE);
  assign xfer_start_o   = start_q;
  assign xfer_run_o     = (state_q == ST_XFER) || (state_q == ST_WAIT_DONE);
  assign park_o         = (state_q == ST_PARK);
  assign cfg_page_o     = page_q;
  assign state_o        = state_q;
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk #(
  parameter int PAGE_W = 3,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        state_o,
  input logic              xfer_start_o,
  input logic              xfer_run_o,
  input logic              tgt_oe_o,
  input logic              park_o,
  input logic              flash_bus_en_o,
  input logic              flash_rd_o,
  input logic [PAGE_W-1:0] cfg_page_o,
  input logic [CNT_W-1:0]  crc_err_cnt_o,
  input logic [CNT_W-1:0]  done_err_cnt_o,
  input logic              status_s,
  input logic              done_s
);
  // R3
  start_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> $past(status_s && !done_s));
  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);
  // R6
  oe_no_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tgt_oe_o |-> !xfer_run_o);
  // R8
  park_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    park_o |=> park_o);
  // R8
  park_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    park_o |-> (!flash_bus_en_o && !flash_rd_o && !xfer_run_o));
  // R1
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 3'd0 && $past(state_o) != 3'd0) |-> $stable(cfg_page_o));
  // R7
  crc_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd6) |-> (!xfer_run_o && !xfer_start_o));
  // R9
  cnt_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crc_err_cnt_o >= $past(crc_err_cnt_o)) && (done_err_cnt_o >= $past(done_err_cnt_o)));
endmodule

bind cfg_seq cfg_seq_chk #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .state_o       (state_o),
  .xfer_start_o  (xfer_start_o),
  .xfer_run_o    (xfer_run_o),
  .tgt_oe_o      (tgt_oe_o),
  .park_o        (park_o),
  .flash_bus_en_o(flash_bus_en_o),
  .flash_rd_o    (flash_rd_o),
  .cfg_page_o    (cfg_page_o),
  .crc_err_cnt_o (crc_err_cnt_o),
  .done_err_cnt_o(done_err_cnt_o),
  .status_s      (status_s),
  .done_s        (done_s)
);

// File: tb/cfg_seq_tb_top.sv
module cfg_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  page_sel;
  logic [15:0] flash_addr, flash_data, opt_cfg;
  logic        flash_rd, flash_valid, bus_en;
  logic        status, done, oe, start, run, last, tick, park;
  logic [2:0]  cfg_page, state;
  logic [3:0]  done_err, crc_err;

  int total = 0, bad = 0;
  int load_cnt = 0, addr_err = 0, run_in_load = 0, start_cnt = 0, tick_cnt = 0;
  bit tick_en = 1'b0;

  always #2.5 clk = ~clk;

  cfg_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .page_sel_i(page_sel),
    .flash_addr_o(flash_addr), .flash_rd_o(flash_rd), .flash_data_i(flash_data),
    .flash_valid_i(flash_valid), .flash_bus_en_o(bus_en),
    .tgt_status_i(status), .tgt_done_i(done), .tgt_oe_o(oe),
    .xfer_start_o(start), .xfer_run_o(run), .xfer_last_i(last), .dclk_tick_i(tick),
    .park_o(park), .cfg_page_o(cfg_page), .opt_cfg_o(opt_cfg),
    .done_err_cnt_o(done_err), .crc_err_cnt_o(crc_err), .state_o(state)
  );

  function automatic logic [15:0] flash_word(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wait_state(input int s, input int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if (int'(state) == s) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic pulse_last();
    last = 1'b1;
    @(negedge clk);
    last = 1'b0;
  endtask

  // flash model plus load-phase monitors
  always @(negedge clk) begin
    if (flash_rd) begin
      bit v;
      v = ($urandom % 3) != 0;
      if (v) begin
        if (flash_addr != 16'h8000 + 16'(load_cnt)) addr_err++;
        load_cnt++;
      end
      flash_data  = flash_word(flash_addr);
      flash_valid = v;
    end else begin
      flash_valid = 1'b0;
    end
    if (state == 3'd1 && run) run_in_load++;
    if (start) start_cnt++;
  end

  // configuration clock tick source
  always @(negedge clk) begin
    tick = tick_en && (($urandom % 4) != 0);
    if (tick && state == 3'd4) tick_cnt++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    bit ok;
    int lowc;
    void'($urandom(32'd7351));
    rst_n = 1'b0; page_sel = 3'd5; status = 1'b0; done = 1'b0; last = 1'b0;
    flash_valid = 1'b0; flash_data = '0; tick = 1'b0;
    repeat (3) @(negedge clk);
    chk(state == 3'd0, "R1 reset state", state, 0);
    chk(oe == 1'b1, "R6 oe idle high", oe, 1);
    chk(run == 1'b0 && start == 1'b0, "R3 no run in reset", run, 0);
    chk(done_err == 0 && crc_err == 0, "R9 counters reset", crc_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    page_sel = 3'd2;

    wait_state(2, 3000, ok);
    chk(ok, "R2 load completes", state, 2);
    chk(load_cnt == 32, "R2 word count", load_cnt, 32);
    chk(addr_err == 0, "R2 address order", addr_err, 0);
    chk(opt_cfg == flash_word(16'h8000), "R2 option word", opt_cfg, flash_word(16'h8000));
    chk(run_in_load == 0, "R2 no transfer during load", run_in_load, 0);
    chk(cfg_page == 3'd5, "R1 page captured once", cfg_page, 5);

    repeat (20) @(negedge clk);
    chk(state == 3'd2 && start_cnt == 0, "R3 status low blocks start", state, 2);
    status = 1'b1; done = 1'b1;
    repeat (10) @(negedge clk);
    chk(state == 3'd2 && start_cnt == 0, "R3 done high blocks start", state, 2);
    done = 1'b0;
    wait_state(3, 10, ok);
    chk(ok, "R3 transfer starts", state, 3);
    chk(start == 1'b1 && run == 1'b1, "R3 start pulse and run", start, 1);
    @(negedge clk);
    chk(start == 1'b0, "R3 start single cycle", start, 0);

    repeat (5 + ($urandom % 30)) @(negedge clk);
    pulse_last();
    chk(state == 3'd4 && run == 1'b1, "R4 last bit to wait-done", state, 4);

    tick_cnt = 0; tick_en = 1'b1;
    wait_state(5, 2000, ok);
    chk(ok, "R5 timeout reached", state, 5);
    chk(tick_cnt == 64, "R5 tick window", tick_cnt, 64);
    chk(done_err == 4'd1, "R5 done error count", done_err, 1);
    status = 1'b0;
    lowc = 0;
    for (int i = 0; i < 100 && oe == 1'b0; i++) begin
      lowc++;
      @(negedge clk);
    end
    tick_en = 1'b0;
    chk(lowc == 16, "R6 oe pulse width", lowc, 16);
    chk(state == 3'd2, "R6 back to wait-ready", state, 2);
    repeat (5) @(negedge clk);
    chk(state == 3'd2, "R6 waits for status release", state, 2);
    status = 1'b1;
    wait_state(3, 10, ok);
    chk(ok, "R6 restart transfer", state, 3);

    repeat (4) @(negedge clk);
    status = 1'b0;
    repeat (2) @(negedge clk);
    chk(state == 3'd3, "R7 two-stage sync delay", state, 3);
    @(negedge clk);
    chk(state == 3'd6 && run == 1'b0, "R7 halt on corruption", state, 6);
    chk(crc_err == 4'd1, "R7 corruption count", crc_err, 1);
    repeat (15) @(negedge clk);
    chk(state == 3'd6, "R7 holds while status low", state, 6);
    status = 1'b1;
    wait_state(3, 10, ok);
    chk(ok, "R7 rearm after release", state, 3);

    pulse_last();
    tick_en = 1'b1;
    repeat (10) @(negedge clk);
    status = 1'b0;
    wait_state(6, 10, ok);
    chk(ok && crc_err == 4'd2, "R7 abort in wait-done", crc_err, 2);
    tick_en = 1'b0;
    status = 1'b1;
    wait_state(3, 10, ok);
    chk(ok, "R7 rearm second", state, 3);

    pulse_last();
    tick_cnt = 0; tick_en = 1'b1;
    for (int i = 0; i < 500 && tick_cnt < 40; i++) @(negedge clk);
    done = 1'b1;
    wait_state(7, 10, ok);
    tick_en = 1'b0;
    chk(ok, "R4 done moves to park", state, 7);
    chk(done_err == 4'd1, "R5 no timeout before window", done_err, 1);
    chk(park == 1'b1 && run == 1'b0, "R8 park outputs", park, 1);
    chk(bus_en == 1'b0 && flash_rd == 1'b0 && flash_addr == 16'h0, "R8 flash released", bus_en, 0);
    for (int i = 0; i < 30; i++) begin
      status = $urandom; done = $urandom; page_sel = $urandom;
      @(negedge clk);
    end
    chk(state == 3'd7 && park == 1'b1, "R8 park holds", state, 7);
    chk(cfg_page == 3'd5, "R1 page unchanged", cfg_page, 5);

    rst_n = 1'b0; page_sel = 3'd3; status = 1'b1; done = 1'b0; load_cnt = 0; addr_err = 0;
    repeat (3) @(negedge clk);
    chk(crc_err == 0 && done_err == 0, "R9 reset clears counters", crc_err, 0);
    rst_n = 1'b1;
    wait_state(3, 3000, ok);
    chk(ok && cfg_page == 3'd3, "R1 page after second reset", cfg_page, 3);
    chk(addr_err == 0 && load_cnt == 32, "R2 reload after reset", load_cnt, 32);
    for (int n = 0; n < 18; n++) begin
      wait_state(3, 20, ok);
      status = 1'b0;
      wait_state(6, 10, ok);
      status = 1'b1;
    end
    chk(crc_err == 4'd15, "R9 saturation", crc_err, 15);
    chk(done_err == 4'd0, "R9 other counter idle", done_err, 0);
    finish_run();
  end
endmodule